// File: doc/BRIEF.md
# Interrupt Message Source with End-of-Interrupt Throttling

This block sits on the device side of an interrupt path. It turns a bank of local interrupt request lines into a stream of outgoing interrupt messages. Each message carries a vector number and a flag that tells the receiver whether the source is edge-triggered or level-triggered. The message leaves through a valid/ready output port, one message per accepted transfer.

Each vector is fixed as either edge or level by a mode register. An edge vector sends one message for each rising edge of its request and never waits for a reply. A level vector sends one message while its request is high. It then goes quiet until a write-type end-of-interrupt (EOI) event arrives for that same vector. If the request is still high after the EOI, the vector sends again. A read-type event on the EOI input is an error: it sets a sticky flag and changes nothing else. An EOI write to a vector that is not waiting sets a separate sticky flag. When several vectors are eligible, the lowest-numbered vector is sent first.

Top module: `irq_msg_source`

## Requirements
- R1: After a synchronous reset, `msg_valid_o`, `eoi_stray_o` and `eoi_rd_err_o` are low, and every vector is in edge mode.
- R2: An edge-mode vector sends exactly one message with `msg_level_o`=0 per rising edge of its request. A request held high does not repeat the message.
- R3: After a level-mode vector's message has been loaded, no further message for that vector appears until a write-type EOI (`eoi_kind_i`=1) names that vector.
- R4: After a matching EOI write, a level request that is still high sends a new message, and a request that is low sends nothing.
- R5: An EOI write naming a vector that is not waiting sets `eoi_stray_o`. The flag stays high until reset, and the write has no other effect.
- R6: A read-type EOI event (`eoi_kind_i`=0) sets `eoi_rd_err_o`, which stays high until reset. It does not release a waiting vector.
- R7: When several vectors are eligible, the lowest index is sent first. At most one message is loaded per cycle. While `msg_valid_o` is high and `msg_ready_i` is low, the vector and flag stay unchanged.
- R8: While an edge vector's message waits in the output for ready, any number of further edges on that vector queue exactly one extra message.
- R9: A cycle with `cfg_we_i` high loads `cfg_mode_i`, where bit v = 1 makes vector v level mode and 0 makes it edge mode. `msg_level_o` reports the mode of the vector being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we_i | input | 1 | Load the trigger-mode register |
| cfg_mode_i | input | NVEC | Trigger mode per vector, 1 = level |
| req_i | input | NVEC | Local interrupt request lines |
| msg_valid_o | output | 1 | Outgoing message is valid |
| msg_ready_i | input | 1 | Receiver accepts the message |
| msg_vec_o | output | VW | Vector number of the message |
| msg_level_o | output | 1 | 1 = level-triggered source, 0 = edge |
| eoi_valid_i | input | 1 | EOI event present this cycle |
| eoi_kind_i | input | 1 | 1 = write (EOI), 0 = read (error) |
| eoi_vec_i | input | VW | Vector named by the EOI event |
| eoi_stray_o | output | 1 | Sticky: EOI write to a non-waiting vector |
| eoi_rd_err_o | output | 1 | Sticky: read-type access on the EOI input |

## Verification
A level request reaches `msg_valid_o` one clock edge after it is driven. An edge request needs two edges: one to register the edge as pending and one to load the output. An EOI releases a level vector on the next edge, and its new message follows one edge later. Both sticky flags rise on the edge that samples the offending event. The bench drives inputs just after a rising edge and samples at the falling edge. A monitor pops the expected vector and flag from a queue only on falling edges where valid and ready are both high, so the order of messages is checked rather than exact cycles. Quiet periods are then checked by waiting several cycles past the longest latency and confirming that the queue is empty and valid is low.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;
  typedef enum logic {TRIG_EDGE = 1'b0, TRIG_LEVEL = 1'b1} trig_e;
  typedef enum logic {EOI_RD = 1'b0, EOI_WR = 1'b1} eoi_kind_e;
endpackage

// File: rtl/irq_msg_slot.sv
// Per-vector state: edge pending bit or level waiting-for-EOI bit.
module irq_msg_slot
  import irq_msg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic mode_i,
  input  logic req_i,
  input  logic grant_i,
  input  logic eoi_hit_i,
  output logic elig_o,
  output logic wait_o
);
  logic req_q, pend_q, wait_q, rise, is_lvl;

  assign is_lvl = (mode_i == TRIG_LEVEL);
  assign rise   = req_i & ~req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      pend_q <= 1'b0;
      wait_q <= 1'b0;
    end else begin
      req_q <= req_i;
      if (is_lvl) begin
        pend_q <= 1'b0;
        wait_q <= (wait_q & ~eoi_hit_i) | grant_i;
      end else begin
        // an edge during the grant cycle stays pending (one extra queued)
        pend_q <= (pend_q & ~grant_i) | rise;
        wait_q <= 1'b0;
      end
    end
  end

  assign elig_o = is_lvl ? (req_i & ~wait_q) : pend_q;
  assign wait_o = wait_q;

  // R3: a vector waiting for EOI is never granted
  p_no_grant_waiting_r3: assert property (@(posedge clk) disable iff (rst)
    wait_q |-> !grant_i);
  // R8: an edge seen while already pending is merged, not lost
  p_edge_merge_r8: assert property (@(posedge clk) disable iff (rst)
    (!is_lvl && pend_q && rise) |=> pend_q);
endmodule

// File: rtl/irq_msg_pick.sv
// Fixed-priority pick: lowest index wins.
module irq_msg_pick #(
  parameter int N = 8,
  parameter int W = 3
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] onehot_o,
  output logic [W-1:0] idx_o,
  output logic         any_o
);
  always_comb begin
    onehot_o = '0;
    idx_o    = '0;
    any_o    = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        onehot_o    = '0;
        onehot_o[i] = 1'b1;
        idx_o       = W'(i);
        any_o       = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_msg_source.sv
module irq_msg_source
  import irq_msg_pkg::*;
#(
  parameter int NVEC = 8,
  localparam int VW = (NVEC > 1) ? $clog2(NVEC) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we_i,
  input  logic [NVEC-1:0] cfg_mode_i,
  input  logic [NVEC-1:0] req_i,
  output logic            msg_valid_o,
  input  logic            msg_ready_i,
  output logic [VW-1:0]   msg_vec_o,
  output logic            msg_level_o,
  input  logic            eoi_valid_i,
  input  logic            eoi_kind_i,
  input  logic [VW-1:0]   eoi_vec_i,
  output logic            eoi_stray_o,
  output logic            eoi_rd_err_o
);
  logic [NVEC-1:0] mode_q, eoi_hit, elig, waiting, pick_oh, grant;
  logic [VW-1:0]   pick_idx;
  logic            pick_any, load_en, eoi_wr, eoi_rd;
  logic            valid_q, lvl_q, stray_q, rderr_q;
  logic [VW-1:0]   vec_q;

  assign eoi_wr = eoi_valid_i & (eoi_kind_i == EOI_WR);
  assign eoi_rd = eoi_valid_i & (eoi_kind_i == EOI_RD);

  always_ff @(posedge clk) begin
    if (rst)           mode_q <= '0;
    else if (cfg_we_i) mode_q <= cfg_mode_i;
  end

  for (genvar v = 0; v < NVEC; v++) begin : g_slot
    assign eoi_hit[v] = eoi_wr && (eoi_vec_i == VW'(v));
    irq_msg_slot u_slot (
      .clk       (clk),
      .rst       (rst),
      .mode_i    (mode_q[v]),
      .req_i     (req_i[v]),
      .grant_i   (grant[v]),
      .eoi_hit_i (eoi_hit[v]),
      .elig_o    (elig[v]),
      .wait_o    (waiting[v])
    );
  end

  irq_msg_pick #(.N(NVEC), .W(VW)) u_pick (
    .req_i    (elig),
    .onehot_o (pick_oh),
    .idx_o    (pick_idx),
    .any_o    (pick_any)
  );

  assign load_en = ~valid_q | msg_ready_i;
  assign grant   = load_en ? pick_oh : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      vec_q   <= '0;
      lvl_q   <= 1'b0;
    end else if (load_en) begin
      valid_q <= pick_any;
      vec_q   <= pick_idx;
      lvl_q   <= mode_q[pick_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stray_q <= 1'b0;
      rderr_q <= 1'b0;
    end else begin
      stray_q <= stray_q | (eoi_wr & ~|(eoi_hit & waiting));
      rderr_q <= rderr_q | eoi_rd;
    end
  end

  assign msg_valid_o  = valid_q;
  assign msg_vec_o    = vec_q;
  assign msg_level_o  = lvl_q;
  assign eoi_stray_o  = stray_q;
  assign eoi_rd_err_o = rderr_q;

  // R7: stalled message holds still
  p_hold_stable_r7: assert property (@(posedge clk) disable iff (rst)
    (msg_valid_o && !msg_ready_i) |=>
      (msg_valid_o && $stable(msg_vec_o) && $stable(msg_level_o)));
  // R7: at most one vector granted per cycle
  p_one_grant_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
  // R5: stray flag is sticky
  p_stray_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    eoi_stray_o |=> eoi_stray_o);
  // R6: read-error flag is sticky and set by a read event
  p_rderr_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (eoi_rd_err_o || eoi_rd) |=> eoi_rd_err_o);
endmodule

// File: tb/sim_irq_msg_source.sv
`timescale 1ns/1ps
module sim_irq_msg_source;
  localparam int NVEC = 8;
  localparam int VW = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic            rst = 1'b1;
  logic            cfg_we = 1'b0;
  logic [NVEC-1:0] cfg_mode = '0;
  logic [NVEC-1:0] req = '0;
  logic            rdy = 1'b1;
  logic            eoi_valid = 1'b0;
  logic            eoi_kind = 1'b1;
  logic [VW-1:0]   eoi_vec = '0;
  logic            msg_valid_o, msg_level_o, eoi_stray_o, eoi_rd_err_o;
  logic [VW-1:0]   msg_vec_o;

  irq_msg_source #(.NVEC(NVEC)) u0 (
    .clk(clk), .rst(rst), .cfg_we_i(cfg_we), .cfg_mode_i(cfg_mode),
    .req_i(req), .msg_valid_o(msg_valid_o), .msg_ready_i(rdy),
    .msg_vec_o(msg_vec_o), .msg_level_o(msg_level_o),
    .eoi_valid_i(eoi_valid), .eoi_kind_i(eoi_kind), .eoi_vec_i(eoi_vec),
    .eoi_stray_o(eoi_stray_o), .eoi_rd_err_o(eoi_rd_err_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  int exp_q[$];
  string tag_q[$];

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // expected item: bit 8 = level flag, low bits = vector
  task automatic expect_msg(input int v, input bit lvl, input string rq);
    exp_q.push_back((int'(lvl) << 8) | v);
    tag_q.push_back(rq);
  endtask

  task automatic send_eoi(input int v, input bit wr);
    eoi_valid = 1'b1;
    eoi_kind  = wr;
    eoi_vec   = VW'(v);
    tick();
    eoi_valid = 1'b0;
  endtask

  task automatic check_idle(input string rq);
    tick(6);
    chk(exp_q.size() == 0, rq, exp_q.size(), 0);
    chk(msg_valid_o == 1'b0, rq, msg_valid_o, 0);
  endtask

  // monitor: one transfer per falling edge with valid & ready
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && msg_valid_o && rdy) begin
        int act;
        act = (int'(msg_level_o) << 8) | int'(msg_vec_o);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7 unexpected message", act, -1);
        end else begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(act == e, t, act, e);
        end
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick();
    // R1: reset state
    chk(msg_valid_o == 1'b0, "R1 valid after reset", msg_valid_o, 0);
    chk(eoi_stray_o == 1'b0, "R1 stray after reset", eoi_stray_o, 0);
    chk(eoi_rd_err_o == 1'b0, "R1 rd_err after reset", eoi_rd_err_o, 0);

    // R1/R2: vector 5 is edge mode at reset, flag 0
    req[5] = 1'b1; expect_msg(5, 1'b0, "R1 default edge mode");
    tick(); req[5] = 1'b0;
    check_idle("R1 drain");

    // R2: held-high edge request sends once
    req[3] = 1'b1; expect_msg(3, 1'b0, "R2 edge held high");
    tick(8); req[3] = 1'b0;
    check_idle("R2 no repeat while high");
    req[3] = 1'b1; expect_msg(3, 1'b0, "R2 second edge");
    tick(); req[3] = 1'b0;
    check_idle("R2 drain");

    // R9: vectors 5 and 6 level
    cfg_mode = 8'b0110_0000; cfg_we = 1'b1;
    tick(); cfg_we = 1'b0;

    // R3: level vector sends once then waits
    req[5] = 1'b1; expect_msg(5, 1'b1, "R9 level flag / R3 first message");
    tick(12);
    chk(exp_q.size() == 0, "R3 first message delivered", exp_q.size(), 0);
    chk(msg_valid_o == 1'b0, "R3 no resend before EOI", msg_valid_o, 0);

    // R4: EOI with request still high resends
    send_eoi(5, 1'b1); expect_msg(5, 1'b1, "R4 resend after EOI");
    check_idle("R4 single resend");

    // R6: read-type EOI flagged, does not release
    send_eoi(5, 1'b0);
    tick(6);
    chk(eoi_rd_err_o == 1'b1, "R6 rd_err set", eoi_rd_err_o, 1);
    chk(msg_valid_o == 1'b0, "R6 read does not release", msg_valid_o, 0);
    chk(eoi_stray_o == 1'b0, "R6 read is not stray", eoi_stray_o, 0);

    // R4: EOI with request low sends nothing
    req[5] = 1'b0; tick();
    send_eoi(5, 1'b1);
    check_idle("R4 no message when request low");
    chk(eoi_stray_o == 1'b0, "R5 matching EOI not stray", eoi_stray_o, 0);

    // R5: EOI to a non-waiting vector
    send_eoi(5, 1'b1);
    tick(2);
    chk(eoi_stray_o == 1'b1, "R5 stray set", eoi_stray_o, 1);
    check_idle("R5 stray has no effect");
    tick(5);
    chk(eoi_stray_o == 1'b1, "R5 stray sticky", eoi_stray_o, 1);
    chk(eoi_rd_err_o == 1'b1, "R6 rd_err sticky", eoi_rd_err_o, 1);

    // R7: lowest index first under stall
    rdy = 1'b0;
    req[7] = 1'b1; req[4] = 1'b1; req[1] = 1'b1;
    expect_msg(1, 1'b0, "R7 order first");
    expect_msg(4, 1'b0, "R7 order second");
    expect_msg(7, 1'b0, "R7 order third");
    tick(); req = '0;
    tick(4);
    chk(msg_valid_o == 1'b1, "R7 valid held while stalled", msg_valid_o, 1);
    chk(msg_vec_o == 3'd1, "R7 lowest vector presented", msg_vec_o, 1);
    rdy = 1'b1;
    check_idle("R7 drain");

    // R8: edges during stall collapse to one extra
    rdy = 1'b0;
    req[2] = 1'b1; tick(); req[2] = 1'b0; tick(3);
    expect_msg(2, 1'b0, "R8 stalled message");
    for (int k = 0; k < 3; k++) begin
      req[2] = 1'b1; tick(); req[2] = 1'b0; tick();
    end
    expect_msg(2, 1'b0, "R8 one extra queued");
    tick(2);
    rdy = 1'b1;
    check_idle("R8 no third message");

    summary();
    $finish;
  end
endmodule